// File: doc/BRIEF.md
# Program-Order Exception Acceptance Unit

This unit sits beside a seven-stage in-order pipeline: two fetch stages, one decode stage, three execute stages (the second and third also access memory) and a write-back stage. Every stage may report an exception for the instruction it holds, with a 4-bit cause and the instruction's tag. Each cycle the unit considers every newly reported exception and every one it is still holding. It accepts the one that belongs to the oldest instruction in program order, whatever order the exceptions were detected in.

Accepting an exception produces a one-cycle strobe with the cause and the tag. In the same cycle it signals a flush of every younger instruction. One cycle later it requests a restart of the faulting instruction. A younger instruction's exception is not kept across an acceptance. The pipeline detects it again when that instruction runs again. While the handler is busy, no exception is accepted and reported exceptions wait in one slot per stage.

Top module: `exc_accept_unit`

## Requirements
- R1: While reset is asserted (rst_n low), acc_vld, flush_vld and restart_vld are 0, and acc_code, acc_tag and restart_tag are 0.
- R2: A report counts only if its cause fits its stage. Stages 0 and 1 (fetch) accept only cause 1 (instruction TLB miss). Stage 2 (decode) accepts only cause 2 (decode-class exception: any illegal-instruction, FPU-disable or trap cause). Stages 4 and 5 (memory) accept only cause 3 (data TLB miss). Stages 3 and 6 never raise. Any other report is ignored and never produces acc_vld.
- R3: When several exceptions are candidates in one cycle, the one with the oldest tag is accepted. Cause 0 means none.
- R4: Tag a is older than tag b when bit TAG_W-1 of (a - b) taken modulo 2^TAG_W is 1. This makes the comparison correct across tag wraparound.
- R5: An exception reported before a clock edge while busy is low gives acc_vld = 1 after that edge, for one cycle, with its cause and tag. When acc_vld is 0, acc_code and acc_tag are 0.
- R6: flush_vld is high exactly when acc_vld is high. At that point every other held or simultaneously reported exception is discarded and is never accepted later.
- R7: restart_vld is high in the cycle after acc_vld. restart_tag equals the accepted tag and holds until the next acceptance.
- R8: While busy is high, acc_vld stays 0 and reported exceptions are held. The oldest one is accepted on the first edge with busy low.
- R9: An exception of an older instruction that is detected later outranks a held exception of a younger instruction.
- R10: While an exception is held for a stage, a new report from the same stage replaces it only if its tag is older.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | NSTG | Per-stage exception report, bit i for stage i |
| raise_code | input | NSTG*4 | Per-stage cause, stage i at bits [4i+3:4i] |
| raise_tag | input | NSTG*TAG_W | Per-stage instruction tag, stage i at slice i |
| busy | input | 1 | Handler busy; blocks acceptance |
| acc_vld | output | 1 | Acceptance strobe |
| acc_code | output | 4 | Accepted cause |
| acc_tag | output | TAG_W | Accepted instruction tag |
| flush_vld | output | 1 | Flush all instructions younger than acc_tag |
| restart_vld | output | 1 | Restart request for the faulting instruction |
| restart_tag | output | TAG_W | Tag of the instruction to re-execute |

## Verification
The bench applies pairs of simultaneous reports where the older instruction sits in a later stage, and pairs that straddle the tag wrap. A design that ranked by stage or by raw tag value would accept the wrong instruction or the wrong cause. It checks that a younger exception is gone after an acceptance and returns only when it is re-reported. It also checks that a data TLB miss detected while busy overtakes a decode exception that was held earlier. A design that kept flushed entries, or served reports in order of arrival, would produce an extra or a misordered strobe. Reports with a cause that does not fit the stage must produce no strobe. Same-stage replacement under busy is tested in both arrival orders, so both "always overwrite" and "keep first" faults are exposed.

// File: rtl/exc_accept_pkg.sv
package exc_accept_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE = 4'd0,
        EXC_ITLB = 4'd1,
        EXC_DEC  = 4'd2,
        EXC_DTLB = 4'd3
    } exc_code_e;

    // Stage index assignment of the pipeline
    localparam int STG_F1 = 0;
    localparam int STG_F2 = 1;
    localparam int STG_ID = 2;
    localparam int STG_E1 = 3;
    localparam int STG_E2 = 4;
    localparam int STG_E3 = 5;
    localparam int STG_WB = 6;

    // Cause that a given stage is able to detect
    function automatic logic [CODE_W-1:0] stage_code(input int s);
        case (s)
            STG_F1, STG_F2: return EXC_ITLB;
            STG_ID:         return EXC_DEC;
            STG_E2, STG_E3: return EXC_DTLB;
            default:        return EXC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/exc_stage_filter.sv
module exc_stage_filter
    import exc_accept_pkg::*;
#(
    parameter int NSTG  = 7
) (
    input  logic [NSTG-1:0]        raise_vld,
    input  logic [NSTG*CODE_W-1:0] raise_code,
    output logic [NSTG-1:0]        legal
);

    for (genvar gi = 0; gi < NSTG; gi++) begin : g_stage
        localparam logic [CODE_W-1:0] EXPECT = stage_code(gi);
        // A report counts only if this stage can detect that cause
        assign legal[gi] = (EXPECT != EXC_NONE) && raise_vld[gi]
                           && (raise_code[gi*CODE_W +: CODE_W] == EXPECT);
    end

endmodule

// File: rtl/exc_slot_merge.sv
module exc_slot_merge
    import exc_accept_pkg::*;
#(
    parameter int NSTG  = 7,
    parameter int TAG_W = 4
) (
    input  logic [NSTG-1:0]        legal,
    input  logic [NSTG*CODE_W-1:0] raise_code,
    input  logic [NSTG*TAG_W-1:0]  raise_tag,
    input  logic [NSTG-1:0]        pend_v,
    input  logic [NSTG*CODE_W-1:0] pend_code,
    input  logic [NSTG*TAG_W-1:0]  pend_tag,
    output logic [NSTG-1:0]        cand_v,
    output logic [NSTG*CODE_W-1:0] cand_code,
    output logic [NSTG*TAG_W-1:0]  cand_tag
);

    for (genvar gi = 0; gi < NSTG; gi++) begin : g_slot
        logic [TAG_W-1:0] dif;
        logic             take_new;

        // New report wins the slot if slot is empty or new tag is older
        assign dif      = raise_tag[gi*TAG_W +: TAG_W] - pend_tag[gi*TAG_W +: TAG_W];
        assign take_new = legal[gi] && (!pend_v[gi] || dif[TAG_W-1]);

        assign cand_v[gi] = legal[gi] | pend_v[gi];
        assign cand_code[gi*CODE_W +: CODE_W] = take_new ? raise_code[gi*CODE_W +: CODE_W]
                                                         : pend_code[gi*CODE_W +: CODE_W];
        assign cand_tag[gi*TAG_W +: TAG_W]    = take_new ? raise_tag[gi*TAG_W +: TAG_W]
                                                         : pend_tag[gi*TAG_W +: TAG_W];
    end

endmodule

// File: rtl/exc_oldest_pick.sv
module exc_oldest_pick
    import exc_accept_pkg::*;
#(
    parameter int NSTG  = 7,
    parameter int TAG_W = 4
) (
    input  logic [NSTG-1:0]        cand_v,
    input  logic [NSTG*CODE_W-1:0] cand_code,
    input  logic [NSTG*TAG_W-1:0]  cand_tag,
    output logic                   found,
    output logic [CODE_W-1:0]      win_code,
    output logic [TAG_W-1:0]       win_tag
);

    logic [TAG_W-1:0] dif;

    always_comb begin
        found    = 1'b0;
        win_code = '0;
        win_tag  = '0;
        dif      = '0;
        for (int i = 0; i < NSTG; i++) begin
            dif = cand_tag[i*TAG_W +: TAG_W] - win_tag;
            if (cand_v[i] && (!found || dif[TAG_W-1])) begin
                found    = 1'b1;
                win_code = cand_code[i*CODE_W +: CODE_W];
                win_tag  = cand_tag[i*TAG_W +: TAG_W];
            end
        end
    end

endmodule

// File: rtl/exc_accept_unit.sv
module exc_accept_unit
    import exc_accept_pkg::*;
#(
    parameter int NSTG  = 7,
    parameter int TAG_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSTG-1:0]        raise_vld,
    input  logic [NSTG*CODE_W-1:0] raise_code,
    input  logic [NSTG*TAG_W-1:0]  raise_tag,
    input  logic                   busy,
    output logic                   acc_vld,
    output logic [CODE_W-1:0]      acc_code,
    output logic [TAG_W-1:0]       acc_tag,
    output logic                   flush_vld,
    output logic                   restart_vld,
    output logic [TAG_W-1:0]       restart_tag
);

    localparam int CODE_BUS = NSTG * CODE_W;
    localparam int TAG_BUS  = NSTG * TAG_W;

    typedef struct packed {
        logic [NSTG-1:0]     pv;
        logic [CODE_BUS-1:0] pc;
        logic [TAG_BUS-1:0]  pt;
        logic                acc;
        logic [CODE_W-1:0]   code;
        logic [TAG_W-1:0]    tag;
        logic                fl;
        logic                rs;
        logic [TAG_W-1:0]    rtag;
    } state_t;

    state_t st_d, st_q;

    logic [NSTG-1:0]     legal;
    logic [NSTG-1:0]     cand_v;
    logic [CODE_BUS-1:0] cand_code;
    logic [TAG_BUS-1:0]  cand_tag;
    logic                win_found;
    logic [CODE_W-1:0]   win_code;
    logic [TAG_W-1:0]    win_tag;

    exc_stage_filter #(.NSTG(NSTG)) u_filter (
        .raise_vld  (raise_vld),
        .raise_code (raise_code),
        .legal      (legal)
    );

    exc_slot_merge #(.NSTG(NSTG), .TAG_W(TAG_W)) u_merge (
        .legal      (legal),
        .raise_code (raise_code),
        .raise_tag  (raise_tag),
        .pend_v     (st_q.pv),
        .pend_code  (st_q.pc),
        .pend_tag   (st_q.pt),
        .cand_v     (cand_v),
        .cand_code  (cand_code),
        .cand_tag   (cand_tag)
    );

    exc_oldest_pick #(.NSTG(NSTG), .TAG_W(TAG_W)) u_pick (
        .cand_v    (cand_v),
        .cand_code (cand_code),
        .cand_tag  (cand_tag),
        .found     (win_found),
        .win_code  (win_code),
        .win_tag   (win_tag)
    );

    always_comb begin
        st_d      = st_q;
        st_d.acc  = 1'b0;
        st_d.fl   = 1'b0;
        st_d.code = '0;
        st_d.tag  = '0;
        // Restart follows the acceptance by one cycle
        st_d.rs   = st_q.acc;
        if (st_q.acc) begin
            st_d.rtag = st_q.tag;
        end
        if (win_found && !busy) begin
            st_d.acc  = 1'b1;
            st_d.fl   = 1'b1;
            st_d.code = win_code;
            st_d.tag  = win_tag;
            // Winner is oldest: every other entry is younger and is flushed
            st_d.pv   = '0;
            st_d.pc   = '0;
            st_d.pt   = '0;
        end else begin
            st_d.pv = cand_v;
            st_d.pc = cand_code;
            st_d.pt = cand_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_vld     = st_q.acc;
    assign acc_code    = st_q.code;
    assign acc_tag     = st_q.tag;
    assign flush_vld   = st_q.fl;
    assign restart_vld = st_q.rs;
    assign restart_tag = st_q.rtag;

endmodule

module exc_accept_chk #(
    parameter int NSTG  = 7,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             acc_vld,
    input logic [3:0]       acc_code,
    input logic [TAG_W-1:0] acc_tag,
    input logic             flush_vld,
    input logic             restart_vld,
    input logic [TAG_W-1:0] restart_tag
);

    p_flush_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld == acc_vld);

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |-> (acc_code == 4'd0 && acc_tag == '0));

    p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> (acc_code >= 4'd1 && acc_code <= 4'd3));

    p_restart_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> (restart_vld && restart_tag == $past(acc_tag)));

    p_restart_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_vld |-> $past(acc_vld));

    p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !acc_vld);

endmodule

bind exc_accept_unit exc_accept_chk #(.NSTG(NSTG), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .acc_vld     (acc_vld),
    .acc_code    (acc_code),
    .acc_tag     (acc_tag),
    .flush_vld   (flush_vld),
    .restart_vld (restart_vld),
    .restart_tag (restart_tag)
);

// File: tb/sim_exc_accept_unit.sv
module sim_exc_accept_unit;

    localparam int NSTG  = 7;
    localparam int TAG_W = 4;
    localparam int NVEC  = 10;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NSTG-1:0]       raise_vld;
    logic [NSTG*4-1:0]     raise_code;
    logic [NSTG*TAG_W-1:0] raise_tag;
    logic                  busy;
    logic                  acc_vld;
    logic [3:0]            acc_code;
    logic [TAG_W-1:0]      acc_tag;
    logic                  flush_vld;
    logic                  restart_vld;
    logic [TAG_W-1:0]      restart_tag;

    exc_accept_unit #(.NSTG(NSTG), .TAG_W(TAG_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise_vld   (raise_vld),
        .raise_code  (raise_code),
        .raise_tag   (raise_tag),
        .busy        (busy),
        .acc_vld     (acc_vld),
        .acc_code    (acc_code),
        .acc_tag     (acc_tag),
        .flush_vld   (flush_vld),
        .restart_vld (restart_vld),
        .restart_tag (restart_tag)
    );

    always #5 clk = ~clk;

    // Two reports per vector (stage 7 = no report) and the expected acceptance
    typedef struct packed {
        logic [2:0] sa; logic [3:0] ca; logic [3:0] ta;
        logic [2:0] sb; logic [3:0] cb; logic [3:0] tb;
        logic       ev; logic [3:0] ec; logic [3:0] et;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd2, 4'd2, 4'd11, 3'd0, 4'd1, 4'd12, 1'b1, 4'd2, 4'd11}, // R3 decode n+1 vs fetch n+2
        '{3'd5, 4'd3, 4'd3,  3'd2, 4'd2, 4'd4,  1'b1, 4'd3, 4'd3},  // R3 memory stage older
        '{3'd4, 4'd3, 4'd7,  3'd1, 4'd1, 4'd9,  1'b1, 4'd3, 4'd7},  // R3
        '{3'd5, 4'd3, 4'd15, 3'd2, 4'd2, 4'd1,  1'b1, 4'd3, 4'd15}, // R4 wrap
        '{3'd1, 4'd1, 4'd2,  3'd4, 4'd3, 4'd14, 1'b1, 4'd3, 4'd14}, // R4 wrap
        '{3'd3, 4'd2, 4'd5,  3'd7, 4'd0, 4'd0,  1'b0, 4'd0, 4'd0},  // R2 stage 3 silent
        '{3'd0, 4'd3, 4'd5,  3'd7, 4'd0, 4'd0,  1'b0, 4'd0, 4'd0},  // R2 wrong cause
        '{3'd6, 4'd1, 4'd5,  3'd2, 4'd2, 4'd6,  1'b1, 4'd2, 4'd6},  // R2 write-back silent
        '{3'd2, 4'd0, 4'd5,  3'd7, 4'd0, 4'd0,  1'b0, 4'd0, 4'd0},  // R2 cause 0
        '{3'd0, 4'd1, 4'd8,  3'd7, 4'd0, 4'd0,  1'b1, 4'd1, 4'd8}   // R5 single
    };

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_raise();
        raise_vld  = '0;
        raise_code = '0;
        raise_tag  = '0;
    endtask

    task automatic put(input int s, input int c, input int t);
        if (s < NSTG) begin
            raise_vld[s]            = 1'b1;
            raise_code[s*4 +: 4]    = 4'(c);
            raise_tag[s*TAG_W +: TAG_W] = TAG_W'(t);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // R10: two same-stage reports under busy, the older must be kept
    task automatic slot_keep(input int first, input int second, input int exp);
        busy = 1'b1;
        put(1, 1, first);
        step();
        clr_raise();
        put(1, 1, second);
        step();
        clr_raise();
        busy = 1'b0;
        step();
        chk("R10 acc_vld", acc_vld, 1);
        chk("R10 acc_tag", acc_tag, exp);
        step();
        chk("R10 single strobe", acc_vld, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        busy  = 1'b0;
        clr_raise();
        put(2, 2, 3);
        repeat (3) step();
        // R1 reset state even with a report present
        chk("R1 acc_vld", acc_vld, 0);
        chk("R1 flush_vld", flush_vld, 0);
        chk("R1 restart_vld", restart_vld, 0);
        chk("R1 acc_code", acc_code, 0);
        chk("R1 restart_tag", restart_tag, 0);
        clr_raise();
        rst_n = 1'b1;
        step();

        for (int v = 0; v < NVEC; v++) begin
            clr_raise();
            put(int'(VECS[v].sa), int'(VECS[v].ca), int'(VECS[v].ta));
            put(int'(VECS[v].sb), int'(VECS[v].cb), int'(VECS[v].tb));
            step();
            clr_raise();
            chk("R2/R3 acc_vld", acc_vld, int'(VECS[v].ev));
            chk("R3/R4 acc_code", acc_code, int'(VECS[v].ec));
            chk("R3/R4 acc_tag", acc_tag, int'(VECS[v].et));
            chk("R6 flush_vld", flush_vld, int'(VECS[v].ev));
            step();
            chk("R5/R6 strobe ends", acc_vld, 0);
            chk("R7 restart_vld", restart_vld, int'(VECS[v].ev));
            if (VECS[v].ev) chk("R7 restart_tag", restart_tag, int'(VECS[v].et));
        end

        // R6: younger exception is discarded and only comes back when re-reported
        put(2, 2, 11);
        put(0, 1, 12);
        step();
        clr_raise();
        chk("R6 first acc_tag", acc_tag, 11);
        step();
        chk("R6 no leftover", acc_vld, 0);
        step();
        chk("R6 no leftover later", acc_vld, 0);
        chk("R7 restart_tag held", restart_tag, 11);
        put(0, 1, 12);
        step();
        clr_raise();
        chk("R6 re-reported acc_vld", acc_vld, 1);
        chk("R6 re-reported acc_tag", acc_tag, 12);
        step();

        // R8 hold under busy, R9 later-detected older wins
        busy = 1'b1;
        put(2, 2, 11);
        step();
        clr_raise();
        chk("R8 blocked", acc_vld, 0);
        step();
        chk("R8 still blocked", acc_vld, 0);
        put(5, 3, 10);
        step();
        clr_raise();
        chk("R8 blocked with two", acc_vld, 0);
        busy = 1'b0;
        step();
        chk("R8 released acc_vld", acc_vld, 1);
        chk("R9 older wins code", acc_code, 3);
        chk("R9 older wins tag", acc_tag, 10);
        step();
        chk("R6 held younger flushed", acc_vld, 0);
        step();

        slot_keep(6, 5, 5);
        slot_keep(5, 6, 5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule